// File: doc/BRIEF.md
# Banked display command decoder

This block is the command receiver inside a display panel controller. It takes command packets that an upstream packet layer has already stripped of framing, one byte per cycle. The first byte of a packet is an opcode, marked by a start flag. The parameter bytes follow it, and an end flag marks the last byte. An opcode byte that also carries the end flag is a packet with no parameters. Bytes that arrive outside a packet are ignored.

The block keeps a sticky selection state. This state is a flag that enables an extended command set, plus a 4-bit bank index. Only a keyed select packet can change it. The same extended opcode lands in different registers depending on which bank is active. The stored registers are decoded into panel timing and drive fields, and these drive the rest of the controller directly as outputs: gamma tables, amplitude codes, line count, porches, inversion mode, clocks per line and end-of-transmission enable.

Top module: `cmdbank_decoder`

## Requirements
- R1: A packet with opcode 0xFF and exactly five parameter bytes, 0x77 0x01 0x00 0x00 followed by a select byte S, updates the selection state in the cycle after its last byte. `cmd2_en` becomes S[4]. `bank_sel` becomes S[3:0] when S[4] is 1 and 0 otherwise.
- R2: A 0xFF packet leaves the selection state unchanged if any of its first four parameter bytes differs from the key, or if it carries a number of parameter bytes other than five.
- R3: When the extended set is on and bank 0 is active, opcode 0xB0 writes the positive gamma table and opcode 0xB1 writes the negative gamma table. Each table holds GAMMA_LEN bytes, and parameter k appears on bits [8k+7:8k] of `pos_gamma` or `neg_gamma`.
- R4: When the extended set is on and bank 1 is active, opcode 0xB0 writes `vop_code` and opcode 0xB1 writes `vcom_code`, each from the first parameter byte. The gamma tables are not touched.
- R5: Bank-0 opcode 0xC0 takes two bytes, A and B. The output is `total_lines` = (A[6:0]+1)*8 + (A[7] ? B[1:0]*2 : 0). All other bits of B are ignored.
- R6: Bank-0 opcode 0xC1 loads `vbp` from its first byte and `vfp` from its second byte.
- R7: Bank-0 opcode 0xC2 sets `inv_mode` to bits [2:0] of its first byte and `clocks_per_line` to 512 + 16 * (bits [4:0] of its second byte).
- R8: Bank-1 opcode 0xD0 sets `eot_en` to bit 3 of its byte.
- R9: An opcode from {0xB0, 0xB1, 0xC0, 0xC1, 0xC2, 0xD0} that arrives while the extended set is off writes nothing. It raises `unsup_cmd` for exactly the one cycle after the opcode byte.
- R10: Parameter bytes beyond a register's length are discarded. A packet that ends early updates only the bytes it delivered, and each register byte is visible in the cycle after its byte is received.
- R11: After reset the extended set is off, the bank is 0 and every stored byte is 0. As a result `total_lines` is 8 and `clocks_per_line` is 512.
- R12: An opcode with no register in the active bank writes nothing and raises no `unsup_cmd`. This covers a bank other than 0 or 1, and 0xC0 in bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sop | input | 1 | This byte is an opcode |
| in_eop | input | 1 | This byte ends the packet |
| in_data | input | 8 | Byte value |
| cmd2_en | output | 1 | Extended command set enabled |
| bank_sel | output | 4 | Active bank index |
| unsup_cmd | output | 1 | One-cycle pulse for a dropped extended opcode |
| pos_gamma | output | 8*GAMMA_LEN | Positive gamma table, byte k at [8k+7:8k] |
| neg_gamma | output | 8*GAMMA_LEN | Negative gamma table |
| vop_code | output | 8 | Source amplitude code |
| vcom_code | output | 8 | Common-electrode amplitude code |
| total_lines | output | 11 | Decoded vertical line count |
| vbp | output | 8 | Vertical back porch |
| vfp | output | 8 | Vertical front porch |
| inv_mode | output | 3 | Inversion mode |
| clocks_per_line | output | 10 | Decoded pixel clocks per line |
| eot_en | output | 1 | End-of-transmission enable |

## Verification
The bench builds the block with its default GAMMA_LEN of 16. With that size the whole line-setting space is swept exhaustively: 128 line values, both states of the enable bit and all four deltas. All 32 clock-field values are swept too, and the expected results are computed arithmetically. A 16-byte table is small enough to check overruns and short packets byte by byte. The key is tested with a corruption at each of its four positions and with byte counts on both sides of five. Every extended opcode is sent with the set disabled, and an unmapped bank is selected to confirm that opcodes are routed by bank.

// File: rtl/cmdbank_pkg.sv
package cmdbank_pkg;
    typedef enum logic [3:0] {
        TGT_NONE, TGT_KEY, TGT_PGAM, TGT_NGAM, TGT_VOP,
        TGT_VCOM, TGT_LINE, TGT_PORCH, TGT_INV, TGT_MIPI
    } tgt_e;

    localparam logic [7:0] OP_KEY   = 8'hFF;
    localparam logic [7:0] OP_TBL_A = 8'hB0;
    localparam logic [7:0] OP_TBL_B = 8'hB1;
    localparam logic [7:0] OP_LINE  = 8'hC0;
    localparam logic [7:0] OP_PORCH = 8'hC1;
    localparam logic [7:0] OP_INV   = 8'hC2;
    localparam logic [7:0] OP_MIPI  = 8'hD0;

    localparam int KEY_LEN   = 5;
    localparam int LINE_FW   = 7;
    localparam int LINES_W   = LINE_FW + 4;
    localparam int CLK_BASE  = 512;
    localparam int CLK_W     = $clog2(CLK_BASE) + 1;

    function automatic logic [7:0] key_byte(input logic [2:0] pos);
        case (pos)
            3'd0:    return 8'h77;
            3'd1:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_ext_op(input logic [7:0] op);
        return (op == OP_TBL_A) || (op == OP_TBL_B) || (op == OP_LINE) ||
               (op == OP_PORCH) || (op == OP_INV) || (op == OP_MIPI);
    endfunction
endpackage

// File: rtl/cmd_router.sv
module cmd_router
    import cmdbank_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    output logic             wr_en,
    output tgt_e             wr_tgt,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             cmd2_en,
    output logic [3:0]       bank_sel,
    output logic             unsup
);
    localparam logic [IDX_W-1:0] IDX_MAX  = '1;
    localparam logic [IDX_W-1:0] KEY_LAST = IDX_W'(KEY_LEN - 1);

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        logic             key_ok;
        logic             in_pkt;
        logic             cmd2;
        logic [3:0]       bank;
        logic             unsup;
    } rt_t;

    rt_t rt_d, rt_q;

    function automatic tgt_e decode(input logic [7:0] op, input logic c2,
                                    input logic [3:0] bk);
        tgt_e t;
        t = TGT_NONE;
        if (op == OP_KEY) begin
            t = TGT_KEY;
        end else if (c2 && bk == 4'd0) begin
            case (op)
                OP_TBL_A: t = TGT_PGAM;
                OP_TBL_B: t = TGT_NGAM;
                OP_LINE:  t = TGT_LINE;
                OP_PORCH: t = TGT_PORCH;
                OP_INV:   t = TGT_INV;
                default:  t = TGT_NONE;
            endcase
        end else if (c2 && bk == 4'd1) begin
            case (op)
                OP_TBL_A: t = TGT_VOP;
                OP_TBL_B: t = TGT_VCOM;
                OP_MIPI:  t = TGT_MIPI;
                default:  t = TGT_NONE;
            endcase
        end
        return t;
    endfunction

    always_comb begin
        rt_d       = rt_q;
        rt_d.unsup = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                rt_d.in_pkt = !in_eop;
                rt_d.idx    = '0;
                rt_d.key_ok = 1'b1;
                rt_d.tgt    = decode(in_data, rt_q.cmd2, rt_q.bank);
                rt_d.unsup  = is_ext_op(in_data) && !rt_q.cmd2;
            end else if (rt_q.in_pkt) begin
                if (rt_q.idx < KEY_LAST && in_data != key_byte(rt_q.idx[2:0]))
                    rt_d.key_ok = 1'b0;
                if (rt_q.idx != IDX_MAX)
                    rt_d.idx = rt_q.idx + 1'b1;
                if (in_eop) begin
                    rt_d.in_pkt = 1'b0;
                    if (rt_q.tgt == TGT_KEY && rt_q.key_ok && rt_q.idx == KEY_LAST) begin
                        rt_d.cmd2 = in_data[4];
                        rt_d.bank = in_data[4] ? in_data[3:0] : 4'd0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '{tgt: TGT_NONE, idx: '0, key_ok: 1'b0, in_pkt: 1'b0,
                      cmd2: 1'b0, bank: 4'd0, unsup: 1'b0};
        end else begin
            rt_q <= rt_d;
        end
    end

    assign wr_en    = in_valid && !in_sop && rt_q.in_pkt &&
                      rt_q.tgt != TGT_NONE && rt_q.tgt != TGT_KEY;
    assign wr_tgt   = rt_q.tgt;
    assign wr_idx   = rt_q.idx;
    assign wr_data  = in_data;
    assign cmd2_en  = rt_q.cmd2;
    assign bank_sel = rt_q.bank;
    assign unsup    = rt_q.unsup;

    // R9
    unsup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.unsup |-> !rt_q.cmd2);
    // R1
    sel_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rt_q.cmd2, rt_q.bank}) |-> $past(in_valid && in_eop && !in_sop));
    // R1
    bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_q.cmd2 |-> rt_q.bank == 4'd0);
    // R3
    bank0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_tgt == TGT_PGAM || wr_tgt == TGT_LINE || wr_tgt == TGT_INV))
        |-> (rt_q.cmd2 && rt_q.bank == 4'd0));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cmdbank_pkg::*;
#(
    parameter int GAMMA_LEN = 16,
    parameter int IDX_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  tgt_e                   wr_tgt,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    output logic [GAMMA_LEN*8-1:0] pos_gamma,
    output logic [GAMMA_LEN*8-1:0] neg_gamma,
    output logic [7:0]             vop_code,
    output logic [7:0]             vcom_code,
    output logic [LINES_W-1:0]     total_lines,
    output logic [7:0]             vbp,
    output logic [7:0]             vfp,
    output logic [2:0]             inv_mode,
    output logic [CLK_W-1:0]       clocks_per_line,
    output logic                   eot_en
);
    localparam int GI_W = $clog2(GAMMA_LEN);
    localparam logic [IDX_W-1:0] GLEN = IDX_W'(GAMMA_LEN);

    typedef struct packed {
        logic [GAMMA_LEN-1:0][7:0] pg;
        logic [GAMMA_LEN-1:0][7:0] ng;
        logic [7:0] vop;
        logic [7:0] vcom;
        logic [7:0] ln0;
        logic [7:0] ln1;
        logic [7:0] vbp;
        logic [7:0] vfp;
        logic [7:0] inv0;
        logic [7:0] inv1;
        logic [7:0] mipi;
    } rg_t;

    rg_t rg_d, rg_q;
    logic first, second;

    assign first  = (wr_idx == '0);
    assign second = (wr_idx == IDX_W'(1));

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (wr_tgt)
                TGT_PGAM:  if (wr_idx < GLEN) rg_d.pg[wr_idx[GI_W-1:0]] = wr_data;
                TGT_NGAM:  if (wr_idx < GLEN) rg_d.ng[wr_idx[GI_W-1:0]] = wr_data;
                TGT_VOP:   if (first) rg_d.vop  = wr_data;
                TGT_VCOM:  if (first) rg_d.vcom = wr_data;
                TGT_MIPI:  if (first) rg_d.mipi = wr_data;
                TGT_LINE: begin
                    if (first)  rg_d.ln0 = wr_data;
                    if (second) rg_d.ln1 = wr_data;
                end
                TGT_PORCH: begin
                    if (first)  rg_d.vbp = wr_data;
                    if (second) rg_d.vfp = wr_data;
                end
                TGT_INV: begin
                    if (first)  rg_d.inv0 = wr_data;
                    if (second) rg_d.inv1 = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    logic [LINES_W-1:0] line_base, line_extra;
    assign line_base  = (LINES_W'(rg_q.ln0[LINE_FW-1:0]) + LINES_W'(1)) << 3;
    assign line_extra = rg_q.ln0[7] ? LINES_W'({rg_q.ln1[1:0], 1'b0}) : '0;

    assign pos_gamma       = rg_q.pg;
    assign neg_gamma       = rg_q.ng;
    assign vop_code        = rg_q.vop;
    assign vcom_code       = rg_q.vcom;
    assign total_lines     = line_base + line_extra;
    assign vbp             = rg_q.vbp;
    assign vfp             = rg_q.vfp;
    assign inv_mode        = rg_q.inv0[2:0];
    assign clocks_per_line = CLK_W'(CLK_BASE) + (CLK_W'(rg_q.inv1[4:0]) << 4);
    assign eot_en          = rg_q.mipi[3];

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rg_q));
    // R4
    vop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.vop) |-> $past(wr_en && wr_tgt == TGT_VOP));
    // R3
    gamma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.pg) |-> $past(wr_en && wr_tgt == TGT_PGAM));
endmodule

// File: rtl/cmdbank_decoder.sv
module cmdbank_decoder
    import cmdbank_pkg::*;
#(
    parameter int GAMMA_LEN = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  logic                   in_eop,
    input  logic [7:0]             in_data,
    output logic                   cmd2_en,
    output logic [3:0]             bank_sel,
    output logic                   unsup_cmd,
    output logic [GAMMA_LEN*8-1:0] pos_gamma,
    output logic [GAMMA_LEN*8-1:0] neg_gamma,
    output logic [7:0]             vop_code,
    output logic [7:0]             vcom_code,
    output logic [LINES_W-1:0]     total_lines,
    output logic [7:0]             vbp,
    output logic [7:0]             vfp,
    output logic [2:0]             inv_mode,
    output logic [CLK_W-1:0]       clocks_per_line,
    output logic                   eot_en
);
    localparam int SPAN  = (GAMMA_LEN > KEY_LEN) ? GAMMA_LEN : KEY_LEN;
    localparam int IDX_W = $clog2(SPAN) + 1;

    logic             wr_en;
    tgt_e             wr_tgt;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    cmd_router #(.IDX_W(IDX_W)) u_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_idx(wr_idx), .wr_data(wr_data), .cmd2_en(cmd2_en),
        .bank_sel(bank_sel), .unsup(unsup_cmd)
    );

    cfg_regs #(.GAMMA_LEN(GAMMA_LEN), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_idx(wr_idx), .wr_data(wr_data), .pos_gamma(pos_gamma),
        .neg_gamma(neg_gamma), .vop_code(vop_code), .vcom_code(vcom_code),
        .total_lines(total_lines), .vbp(vbp), .vfp(vfp), .inv_mode(inv_mode),
        .clocks_per_line(clocks_per_line), .eot_en(eot_en)
    );
endmodule

// File: tb/tb_cmdbank_decoder.sv
module tb_cmdbank_decoder;
    localparam int GL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic cmd2_en, unsup_cmd, eot_en;
    logic [3:0] bank_sel;
    logic [GL*8-1:0] pos_gamma, neg_gamma;
    logic [7:0] vop_code, vcom_code, vbp, vfp;
    logic [10:0] total_lines;
    logic [2:0] inv_mode;
    logic [9:0] clocks_per_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] pbuf [0:31];
    logic cap_unsup, post_unsup;
    logic [GL*8-1:0] exp_pg;

    always #5 clk = ~clk;

    cmdbank_decoder #(.GAMMA_LEN(GL)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .cmd2_en(cmd2_en),
        .bank_sel(bank_sel), .unsup_cmd(unsup_cmd), .pos_gamma(pos_gamma),
        .neg_gamma(neg_gamma), .vop_code(vop_code), .vcom_code(vcom_code),
        .total_lines(total_lines), .vbp(vbp), .vfp(vfp), .inv_mode(inv_mode),
        .clocks_per_line(clocks_per_line), .eot_en(eot_en)
    );

    task automatic chk(input string tag, input logic [GL*8-1:0] act,
                       input logic [GL*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input int n);
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_data = op; in_eop = (n == 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) cap_unsup = unsup_cmd;
            in_sop = 1'b0; in_data = pbuf[i]; in_eop = (i == n - 1);
        end
        @(negedge clk);
        if (n == 0) cap_unsup = unsup_cmd;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
        @(negedge clk);
        post_unsup = unsup_cmd;
    endtask

    task automatic select(input logic [7:0] s);
        pbuf[0] = 8'h77; pbuf[1] = 8'h01; pbuf[2] = 8'h00; pbuf[3] = 8'h00;
        pbuf[4] = s;
        send(8'hFF, 5);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] ext_ops [0:5];
        ext_ops[0] = 8'hB0; ext_ops[1] = 8'hB1; ext_ops[2] = 8'hC0;
        ext_ops[3] = 8'hC1; ext_ops[4] = 8'hC2; ext_ops[5] = 8'hD0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 cmd2", cmd2_en, 0);
        chk("R11 bank", bank_sel, 0);
        chk("R11 lines", total_lines, 8);
        chk("R11 clocks", clocks_per_line, 512);
        chk("R11 vop", vop_code, 0);
        chk("R11 unsup", unsup_cmd, 0);

        // R9 extended opcodes with set disabled
        for (int k = 0; k < 6; k++) begin
            pbuf[0] = 8'hAA; pbuf[1] = 8'h55;
            send(ext_ops[k], 2);
            chk("R9 pulse", cap_unsup, 1);
            chk("R9 pulse width", post_unsup, 0);
        end
        chk("R9 gamma dropped", pos_gamma, 0);
        chk("R9 lines dropped", total_lines, 8);
        chk("R9 porch dropped", {vbp, vfp}, 0);

        // R2 corrupt key at each position
        for (int p = 0; p < 4; p++) begin
            pbuf[0] = 8'h77; pbuf[1] = 8'h01; pbuf[2] = 8'h00; pbuf[3] = 8'h00;
            pbuf[4] = 8'h10;
            pbuf[p] = pbuf[p] ^ 8'h80;
            send(8'hFF, 5);
            chk("R2 bad key", cmd2_en, 0);
        end
        pbuf[0] = 8'h77; pbuf[1] = 8'h01; pbuf[2] = 8'h00; pbuf[3] = 8'h10;
        send(8'hFF, 4);
        chk("R2 short key", cmd2_en, 0);
        pbuf[3] = 8'h00; pbuf[4] = 8'h10; pbuf[5] = 8'h00;
        send(8'hFF, 6);
        chk("R2 long key", cmd2_en, 0);

        // R1 enter bank 0
        select(8'h10);
        chk("R1 cmd2 on", cmd2_en, 1);
        chk("R1 bank0", bank_sel, 0);

        // R5 exhaustive line sweep
        for (int ln = 0; ln < 128; ln++)
            for (int en = 0; en < 2; en++)
                for (int dl = 0; dl < 4; dl++) begin
                    pbuf[0] = {en[0], ln[6:0]};
                    pbuf[1] = {ln[5:0], dl[1:0]};
                    send(8'hC0, 2);
                    chk("R5 lines", total_lines, (ln + 1) * 8 + (en != 0 ? dl * 2 : 0));
                    chk("R5 no pulse", cap_unsup, 0);
                end

        // R7 clock field sweep
        for (int r = 0; r < 32; r++) begin
            pbuf[0] = {r[4:0], r[2:0]};
            pbuf[1] = {3'b111, r[4:0]};
            send(8'hC2, 2);
            chk("R7 clocks", clocks_per_line, 512 + 16 * r);
            chk("R7 inv", inv_mode, r % 8);
        end

        // R6 porch
        pbuf[0] = 8'h12; pbuf[1] = 8'h34;
        send(8'hC1, 2);
        chk("R6 vbp", vbp, 8'h12);
        chk("R6 vfp", vfp, 8'h34);

        // R3 gamma tables
        for (int i = 0; i < GL; i++) begin
            pbuf[i] = 8'(i * 7 + 3);
            exp_pg[i*8 +: 8] = 8'(i * 7 + 3);
        end
        send(8'hB0, GL);
        chk("R3 pos gamma", pos_gamma, exp_pg);
        for (int i = 0; i < GL; i++) pbuf[i] = 8'(i) ^ 8'h5A;
        send(8'hB1, GL);
        begin
            logic [GL*8-1:0] e;
            for (int i = 0; i < GL; i++) e[i*8 +: 8] = 8'(i) ^ 8'h5A;
            chk("R3 neg gamma", neg_gamma, e);
        end
        chk("R3 vop untouched", vop_code, 0);

        // R10 excess and short packets
        for (int i = 0; i < GL + 2; i++) pbuf[i] = 8'(i * 7 + 3);
        send(8'hB0, GL + 2);
        chk("R10 gamma overrun", pos_gamma, exp_pg);
        pbuf[0] = 8'hE1; pbuf[1] = 8'hE2; pbuf[2] = 8'hE3;
        send(8'hB0, 3);
        exp_pg[23:0] = 24'hE3E2E1;
        chk("R10 gamma short", pos_gamma, exp_pg);
        pbuf[0] = 8'h21; pbuf[1] = 8'h43; pbuf[2] = 8'h99;
        send(8'hC1, 3);
        chk("R10 porch overrun", {vbp, vfp}, 16'h2143);
        pbuf[0] = 8'h55;
        send(8'hC1, 1);
        chk("R10 porch short", {vbp, vfp}, 16'h5543);

        // R4 bank 1
        select(8'h11);
        chk("R1 bank1", bank_sel, 1);
        pbuf[0] = 8'h4C;
        send(8'hB0, 1);
        chk("R4 vop", vop_code, 8'h4C);
        pbuf[0] = 8'h13;
        send(8'hB1, 1);
        chk("R4 vcom", vcom_code, 8'h13);
        chk("R4 gamma kept", pos_gamma, exp_pg);
        pbuf[0] = 8'h88;
        send(8'hD0, 1);
        chk("R8 eot on", eot_en, 1);
        pbuf[0] = 8'h80;
        send(8'hD0, 1);
        chk("R8 eot off", eot_en, 0);
        pbuf[0] = 8'h00; pbuf[1] = 8'h00;
        send(8'hC0, 2);
        chk("R12 line in bank1", total_lines, 1024 + 6);
        chk("R12 no pulse", cap_unsup, 0);

        // R2 bad key keeps bank 1
        pbuf[0] = 8'h77; pbuf[1] = 8'h02; pbuf[2] = 8'h00; pbuf[3] = 8'h00;
        pbuf[4] = 8'h10;
        send(8'hFF, 5);
        chk("R2 keep bank", bank_sel, 1);

        // R12 unmapped bank
        select(8'h13);
        chk("R12 bank3", bank_sel, 3);
        pbuf[0] = 8'h99;
        send(8'hB0, 1);
        chk("R12 vop kept", vop_code, 8'h4C);
        chk("R12 no pulse b3", cap_unsup, 0);

        // R1 leave extended set
        select(8'h05);
        chk("R1 cmd2 off", cmd2_en, 0);
        chk("R1 bank cleared", bank_sel, 0);
        pbuf[0] = 8'h01;
        send(8'hB0, 1);
        chk("R9 pulse again", cap_unsup, 1);
        chk("R9 vop kept", vop_code, 8'h4C);

        finish_run();
    end
endmodule